// File: doc/BRIEF.md
# Configurable Branch Metric Generator

This block feeds a rate-1/2 soft-decision Viterbi decoder whose constraint length can be chosen at run time from 7 to 10. Each trellis step it takes two 3-bit soft symbols and forms the four possible branch metrics, one for each hypothesised coded bit pair. Four butterfly lanes each pick one of those four metrics through a 2-bit selector. The selector comes from a per-lane 128-entry lookup table. The tables are computed at elaboration from two generator polynomials per constraint length.

A small state machine paces the tables in step with the butterfly schedule. A trellis step lasts 8, 16, 32 or 64 cycles, one cycle for every four butterflies. On each cycle the table address is the window base of the active constraint length plus the cycle count within the step. The constraint-length setting and the two symbols are captured only at the start of a step.

The sequencer has three states. `ST_IDLE` is held during reset. `ST_HEAD` is cycle 0 of a step. `ST_BODY` covers cycles 1 to the end of the window. Its transitions are:
- `ST_IDLE` to `ST_HEAD` on the first edge after reset is released.
- `ST_HEAD` to `ST_BODY` always.
- `ST_BODY` to `ST_BODY` while the count is below the last cycle of the window.
- `ST_BODY` to `ST_HEAD` when the count reaches the last cycle.

Every entry into `ST_HEAD` captures the configuration and the symbols.

Top module: `branch_metric_gen`

## Requirements
- R1: While reset is low, step_head, step_cycle, lane_idx and lane_bm are all zero.
- R2: For selector h = {h1,h0}, the metric is d(sym_a,h1) + d(sym_b,h0). Here d(s,0) = s and d(s,1) = 7 - s, so 0 means a confident 0 and 7 a confident 1. The largest metric is 14.
- R3: Lane l outputs the metric chosen by its own selector. The selector is lane_idx[2l+1:2l] and the metric is lane_bm[4l+3:4l].
- R4: On cycle c of a step with constraint length K, lane l serves butterfly j = 4c + l. Let w = 2j. Bit 1 of the selector is the parity of w AND GEN_A[K], and bit 0 is the parity of w AND GEN_B[K]. The octal defaults are 171/133 (K=7), 371/247 (K=8), 561/753 (K=9) and 1167/1545 (K=10).
- R5: cfg_k encodes K = 7 + cfg_k. The step length is 8 << cfg_k cycles, and that window starts at table address 8 << cfg_k. Addresses 0 to 7 are never used.
- R6: step_cycle counts 0 up to the step length minus 1 and then wraps to 0. step_head is high exactly on cycle 0.
- R7: cfg_k is sampled only on the edge that starts a step. A change made mid-step leaves the current step's length and selectors unchanged.
- R8: sym_a and sym_b are sampled only on the edge that starts a step. A change made mid-step leaves the current step's metrics unchanged.
- R9: The first step begins on the first clock edge after reset is released, using the cfg_k and symbols present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_k | input | 2 | Constraint-length select, K = 7 + cfg_k |
| sym_a | input | 3 | Soft value of the first coded bit |
| sym_b | input | 3 | Soft value of the second coded bit |
| step_head | output | 1 | High on cycle 0 of each trellis step |
| step_cycle | output | 6 | Cycle count within the current step |
| lane_idx | output | 8 | Four 2-bit metric selectors, lane 0 in the low bits |
| lane_bm | output | 16 | Four 4-bit branch metrics, lane 0 in the low bits |

## Verification
The bench builds the block with its default parameters: four lanes, 3-bit soft values, 128-deep tables and the default polynomials. These settings bring all four constraint-length windows within reach, from the 8-cycle step to the 64-cycle step. They also cover the full 0 to 7 soft range, including both saturated extremes where a metric reaches 0 or 14. Selectors are recomputed from the polynomials on every cycle of every lane. Mid-step changes of configuration and symbols, and a reset taken in the middle of a step, are driven explicitly.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

    localparam int NUM_K  = 4;
    localparam int K_MIN  = 7;
    localparam int G_W    = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } seq_state_t;

    typedef logic [NUM_K-1:0][G_W-1:0] gen_set_t;

    // selector for one lane at one table address
    function automatic logic [1:0] index_of(input int lanes, input int lane,
                                            input int addr, input int min_win,
                                            input gen_set_t ga, input gen_set_t gb);
        int k;
        int base;
        int j;
        logic [G_W-1:0] w;
        logic [G_W-1:0] mask;
        if (addr < min_win) begin
            return 2'b00;
        end
        k = 0;
        for (int t = 1; t < NUM_K; t++) begin
            if (addr >= (min_win << t)) k = t;
        end
        base = min_win << k;
        j    = (addr - base) * lanes + lane;
        w    = G_W'(j << 1);
        mask = G_W'((1 << (K_MIN + k)) - 1);
        return {^(w & mask & ga[k]), ^(w & mask & gb[k])};
    endfunction

endpackage

// File: rtl/bmg_seq.sv
module bmg_seq
    import bmg_pkg::*;
#(
    parameter int CYC_W   = 6,
    parameter int AW      = 7,
    parameter int MIN_WIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_k,
    output seq_state_t       state,
    output logic [CYC_W-1:0] cnt,
    output logic [AW-1:0]    rom_addr,
    output logic             load
);

    seq_state_t        nxt;
    logic [1:0]        k_q;
    logic [AW-1:0]     win;
    logic [CYC_W-1:0]  last;

    always_comb begin
        win  = AW'(MIN_WIN) << k_q;
        last = CYC_W'(win - AW'(1));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_HEAD;
            ST_HEAD: nxt = ST_BODY;
            ST_BODY: nxt = (cnt == last) ? ST_HEAD : ST_BODY;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            k_q   <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_HEAD) begin
                cnt <= '0;
                k_q <= cfg_k;
            end else begin
                cnt <= cnt + CYC_W'(1);
            end
        end
    end

    always_comb begin
        load     = (nxt == ST_HEAD);
        rom_addr = win + AW'(cnt);
    end

    // R6
    cyc_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt <= last));

    // R6
    head_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEAD) |-> (cnt == '0));

    // R5
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && cnt == last) |=> (state == ST_HEAD));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> $stable(k_q));

endmodule

// File: rtl/bmg_index_rom.sv
module bmg_index_rom
    import bmg_pkg::*;
#(
    parameter int       LANE    = 0,
    parameter int       LANES   = 4,
    parameter int       DEPTH   = 128,
    parameter int       AW      = 7,
    parameter int       MIN_WIN = 8,
    parameter gen_set_t GEN_A   = '0,
    parameter gen_set_t GEN_B   = '0
) (
    input  logic [AW-1:0] addr,
    output logic [1:0]    idx
);

    logic [1:0] table_w [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam logic [1:0] ENTRY = index_of(LANES, LANE, a, MIN_WIN, GEN_A, GEN_B);
        assign table_w[a] = ENTRY;
    end

    assign idx = table_w[addr];

endmodule

// File: rtl/bmg_metric.sv
module bmg_metric #(
    parameter int SOFT_W = 3,
    parameter int BM_W   = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]       s_a,
    input  logic [SOFT_W-1:0]       s_b,
    output logic [3:0][BM_W-1:0]    bm
);

    localparam logic [SOFT_W-1:0] SMAX = '1;

    logic [SOFT_W-1:0] da [2];
    logic [SOFT_W-1:0] db [2];

    always_comb begin
        da[0] = s_a;
        da[1] = SMAX - s_a;
        db[0] = s_b;
        db[1] = SMAX - s_b;
    end

    for (genvar h = 0; h < 4; h++) begin : g_hyp
        assign bm[h] = BM_W'(da[(h >> 1) & 1]) + BM_W'(db[h & 1]);
    end

endmodule

// File: rtl/branch_metric_gen.sv
module branch_metric_gen
    import bmg_pkg::*;
#(
    parameter int       LANES     = 4,
    parameter int       SOFT_W    = 3,
    parameter int       ROM_DEPTH = 128,
    parameter gen_set_t GEN_A     = {10'o1167, 10'o561, 10'o371, 10'o171},
    parameter gen_set_t GEN_B     = {10'o1545, 10'o753, 10'o247, 10'o133}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cfg_k,
    input  logic [SOFT_W-1:0]           sym_a,
    input  logic [SOFT_W-1:0]           sym_b,
    output logic                        step_head,
    output logic [$clog2(ROM_DEPTH)-2:0] step_cycle,
    output logic [LANES*2-1:0]          lane_idx,
    output logic [LANES*(SOFT_W+1)-1:0] lane_bm
);

    localparam int BM_W    = SOFT_W + 1;
    localparam int AW      = $clog2(ROM_DEPTH);
    localparam int CYC_W   = AW - 1;
    localparam int MIN_WIN = ROM_DEPTH / 16;
    localparam logic [BM_W:0] BM_PAIR = (BM_W+1)'(2 * ((1 << SOFT_W) - 1));

    seq_state_t            state;
    logic [CYC_W-1:0]      cnt;
    logic [AW-1:0]         rom_addr;
    logic                  load;
    logic [SOFT_W-1:0]     sa_q;
    logic [SOFT_W-1:0]     sb_q;
    logic [3:0][BM_W-1:0]  bm_all;
    logic [1:0]            idx_w [LANES];
    logic                  active;

    bmg_seq #(.CYC_W(CYC_W), .AW(AW), .MIN_WIN(MIN_WIN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_k    (cfg_k),
        .state    (state),
        .cnt      (cnt),
        .rom_addr (rom_addr),
        .load     (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            sb_q <= '0;
        end else if (load) begin
            sa_q <= sym_a;
            sb_q <= sym_b;
        end
    end

    bmg_metric #(.SOFT_W(SOFT_W), .BM_W(BM_W)) u_metric (
        .s_a (sa_q),
        .s_b (sb_q),
        .bm  (bm_all)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bmg_index_rom #(
            .LANE(l), .LANES(LANES), .DEPTH(ROM_DEPTH), .AW(AW),
            .MIN_WIN(MIN_WIN), .GEN_A(GEN_A), .GEN_B(GEN_B)
        ) u_rom (
            .addr (rom_addr),
            .idx  (idx_w[l])
        );
        always_comb begin
            lane_idx[2*l +: 2]       = active ? idx_w[l] : 2'b00;
            lane_bm[BM_W*l +: BM_W]  = active ? bm_all[idx_w[l]] : '0;
        end
    end

    always_comb begin
        active     = (state != ST_IDLE);
        step_head  = (state == ST_HEAD);
        step_cycle = active ? cnt : '0;
    end

    // R8
    sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> $stable({sa_q, sb_q}));

    // R2
    metric_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (({1'b0, bm_all[0]} + {1'b0, bm_all[3]}) == BM_PAIR));

    // R2
    metric_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (({1'b0, bm_all[1]} + {1'b0, bm_all[2]}) == BM_PAIR));

    // R1
    idle_quiet_chk: assert property (@(posedge clk)
        (state == ST_IDLE) |-> (lane_bm == '0 && lane_idx == '0 && !step_head));

endmodule

// File: tb/branch_metric_gen_test.sv
module branch_metric_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0][9:0] GA = {10'o1167, 10'o561, 10'o371, 10'o171};
    localparam logic [3:0][9:0] GB = {10'o1545, 10'o753, 10'o247, 10'o133};
    // {cfg_k, sym_a, sym_b}
    localparam logic [7:0] VEC [10] = '{
        {2'd0, 3'd0, 3'd0}, {2'd0, 3'd7, 3'd7}, {2'd1, 3'd0, 3'd7},
        {2'd1, 3'd7, 3'd0}, {2'd2, 3'd3, 3'd4}, {2'd2, 3'd6, 3'd1},
        {2'd3, 3'd2, 3'd5}, {2'd3, 3'd7, 3'd3}, {2'd0, 3'd4, 3'd1},
        {2'd1, 3'd5, 3'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_k;
    logic [2:0] sym_a, sym_b;
    logic       step_head;
    logic [5:0] step_cycle;
    logic [7:0] lane_idx;
    logic [15:0] lane_bm;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_metric_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .sym_a(sym_a), .sym_b(sym_b),
        .step_head(step_head), .step_cycle(step_cycle),
        .lane_idx(lane_idx), .lane_bm(lane_bm)
    );

    function automatic logic [1:0] exp_idx(input int k, input int c, input int l);
        logic [9:0] w;
        w = 10'((c * 4 + l) * 2);
        return {^(w & GA[k]), ^(w & GB[k])};
    endfunction

    function automatic int exp_bm(input logic [1:0] h, input int s0, input int s1);
        return (h[1] ? 7 - s0 : s0) + (h[0] ? 7 - s1 : s1);
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_lanes(input string req, input int k, input int c, input int s0, input int s1);
        for (int l = 0; l < 4; l++) begin
            logic [1:0] e;
            e = exp_idx(k, c, l);
            check_eq(req, "selector", int'(lane_idx[2*l +: 2]), int'(e));
            check_eq(req, "metric", int'(lane_bm[4*l +: 4]), exp_bm(e, s0, s1));
        end
    endtask

    // called at the negedge of a step's cycle 0; returns at the next head
    task automatic check_step(input int k, input int s0, input int s1);
        int n;
        n = 8 << k;
        for (int c = 0; c < n; c++) begin
            check_eq("R6", "cycle", int'(step_cycle), c);
            check_eq("R6", "head", int'(step_head), (c == 0) ? 1 : 0);
            check_lanes("R2 R3 R4", k, c, s0, s1);
            @(negedge clk);
        end
        check_eq("R5", "step length", int'(step_head), 1);
    endtask

    task automatic check_quiet(input string req);
        check_eq(req, "head", int'(step_head), 0);
        check_eq(req, "cycle", int'(step_cycle), 0);
        check_eq(req, "selectors", int'(lane_idx), 0);
        check_eq(req, "metrics", int'(lane_bm), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_k = 2'd0;
        sym_a = 3'd2;
        sym_b = 3'd5;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R9: first edge after release starts a step
        check_eq("R9", "first head", int'(step_head), 1);
        check_step(0, 2, 5);

        for (int v = 0; v < 10; v++) begin
            cfg_k = VEC[v][7:6];
            sym_a = VEC[v][5:3];
            sym_b = VEC[v][2:0];
            @(negedge clk);
            while (!step_head) @(negedge clk);
            check_step(int'(VEC[v][7:6]), int'(VEC[v][5:3]), int'(VEC[v][2:0]));
        end

        // R7 R8: mid-step changes take effect only at the next boundary
        cfg_k = 2'd0;
        sym_a = 3'd1;
        sym_b = 3'd6;
        @(negedge clk);
        while (!step_head) @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            check_eq("R7", "cycle", int'(step_cycle), c);
            check_lanes("R8", 0, c, 1, 6);
            if (c == 3) begin
                cfg_k = 2'd3;
                sym_a = 3'd5;
                sym_b = 3'd2;
            end
            @(negedge clk);
        end
        check_eq("R7", "old length kept", int'(step_head), 1);
        check_step(3, 5, 2);

        // R1: reset taken mid-step
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R9", "restart head", int'(step_head), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule